// File: doc/BRIEF.md
# Dual-Stream Clock Gear Divider

This block derives two clock-enable streams, one for the core domain and one for the bus domain, from a single base clock. Each stream has its own 3-bit divisor code, and both codes sit side by side in one gear control word. Each enable is a single-cycle pulse that recurs once per divided period: every cycle at full speed, every second cycle at half speed, and so on up to one pulse in thirty-two. Logic downstream qualifies its flops with these enables in place of a separate clock.

A new divisor can be written at any time without a reset. The stream keeps its current ratio until its period in progress ends with a pulse, then changes over, so no period is ever cut short. On exit from a low-power state both codes return to full speed only when the wake-up source was a reset; any other wake-up keeps the reduced setting. A full-speed status output lets a refresh-period reprogramming path confirm that the core stream is undivided.

Top module: `clock_gear`

## Requirements
- R1: After the synchronous reset releases, both enables are high every cycle and `core_full_speed` is high.
- R2: Field codes 0, 1, 2, 3 and 4 give one single-cycle pulse every 1, 2, 4, 8 and 16 cycles. The core code is `gear_wdata[2:0]` and the bus code is `gear_wdata[5:3]`. Both are loaded when `gear_wr` is high.
- R3: Code 5 gives one pulse every 32 cycles when `ENABLE_DIV32` is 1, and one pulse every 16 cycles when it is 0.
- R4: The reserved codes 6 and 7 behave as code 0, with a pulse every cycle.
- R5: The core and bus streams are independent: a code in one field has no effect on the other stream's pulse pattern.
- R6: A written code takes effect at the next pulse of the ratio in force. The new period is counted from that pulse, so the interval before it is never shortened.
- R7: A pulse on `lp_exit` with `lp_wake_rst` high returns both codes to 0, and each stream adopts full speed at its next pulse.
- R8: A pulse on `lp_exit` with `lp_wake_rst` low leaves both codes and both pulse patterns unchanged.
- R9: `core_full_speed` is high exactly when the stored core code decodes to divide-by-1 and the core stream's ratio in force is divide-by-1. The bus code has no effect on it.
- R10: When a register write and a reset-sourced low-power exit fall in the same cycle, the exit wins and both codes become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| gear_wr | input | 1 | Write strobe for the gear control word |
| gear_wdata | input | 6 | Gear word: bus code [5:3], core code [2:0] |
| lp_exit | input | 1 | One-cycle pulse when a low-power state is left |
| lp_wake_rst | input | 1 | High if the wake-up source of that exit was a reset |
| core_ce | output | 1 | Core-domain enable pulse |
| bus_ce | output | 1 | Bus-domain enable pulse |
| core_full_speed | output | 1 | Core stream stored and in force at divide-by-1 |

## Verification
The dividers are driven with differing core and bus codes, so that a stream taking its ratio from the wrong field shows up as a wrong pulse spacing. Every code from 0 to 7 is written. Two instances run side by side, one with the 1/32 option on and one with it off, so the two meanings of code 5 are told apart on the same stimulus. Codes are rewritten in the middle of a long period to separate changeover at the period boundary from an immediate change. Low-power exits are given with and without a reset source, and one exit falls in the same cycle as a write, which shows whether the wake-up source is decoded and which of the two takes priority.

// File: rtl/clkgear_pkg.sv
package clkgear_pkg;

    localparam int GEAR_W  = 3;
    localparam int MAX_LOG = 5;
    localparam int LOG_W   = 3;
    localparam int NSTREAM = 2;

    typedef enum logic [GEAR_W-1:0] {
        GEAR_D1   = 3'd0,
        GEAR_D2   = 3'd1,
        GEAR_D4   = 3'd2,
        GEAR_D8   = 3'd3,
        GEAR_D16  = 3'd4,
        GEAR_D32  = 3'd5,
        GEAR_RSV6 = 3'd6,
        GEAR_RSV7 = 3'd7
    } gear_code_e;

    // Upper field drives the bus stream, lower field the core stream.
    typedef struct packed {
        gear_code_e bus;
        gear_code_e core;
    } gear_ctrl_t;

    typedef logic [LOG_W-1:0] log2_t;

    // Map a field code to the base-2 log of its division ratio.
    function automatic log2_t gear_log2(gear_code_e code, bit en32);
        log2_t r;
        case (code)
            GEAR_D2:  r = 3'd1;
            GEAR_D4:  r = 3'd2;
            GEAR_D8:  r = 3'd3;
            GEAR_D16: r = 3'd4;
            GEAR_D32: r = en32 ? 3'd5 : 3'd4;
            default:  r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkgear_ctrl.sv
module clkgear_ctrl
    import clkgear_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  gear_ctrl_t wr_data,
    input  logic       lp_exit,
    input  logic       lp_wake_rst,
    output gear_ctrl_t ctrl_q
);

    logic restore;
    assign restore = lp_exit && lp_wake_rst;

    always_ff @(posedge clk) begin
        if (rst || restore) begin
            ctrl_q.core <= GEAR_D1;
            ctrl_q.bus  <= GEAR_D1;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end

    // R7 R10
    reset_wake_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (lp_exit && lp_wake_rst) |=> (ctrl_q.core == GEAR_D1 && ctrl_q.bus == GEAR_D1));

    // R8
    plain_wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lp_exit && !lp_wake_rst && !wr_en) |=> $stable(ctrl_q));

endmodule

// File: rtl/clkgear_div.sv
module clkgear_div
    import clkgear_pkg::*;
#(
    parameter bit ENABLE_DIV32 = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  gear_code_e code,
    output logic       ce,
    output log2_t      act_log2
);

    localparam int CNT_W = MAX_LOG;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;

    // Terminal count of the ratio in force: 2**act_log2 - 1.
    assign term = ~({CNT_W{1'b1}} << act_log2);
    assign ce   = (cnt == term);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            act_log2 <= '0;
        end else if (ce) begin
            cnt      <= '0;
            act_log2 <= gear_log2(code, ENABLE_DIV32);
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end

    // R2
    full_rate_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (act_log2 == '0) |-> ce);

    // R6
    ratio_change_at_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_log2) |-> $past(ce));

    // R2
    count_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> (cnt == $past(cnt) + 1'b1));

    // R3
    ratio_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ENABLE_DIV32 ? (act_log2 <= 3'd5) : (act_log2 <= 3'd4));

endmodule

// File: rtl/clock_gear.sv
module clock_gear
    import clkgear_pkg::*;
#(
    parameter bit ENABLE_DIV32 = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       gear_wr,
    input  logic [5:0] gear_wdata,
    input  logic       lp_exit,
    input  logic       lp_wake_rst,
    output logic       core_ce,
    output logic       bus_ce,
    output logic       core_full_speed
);

    localparam int CORE_IDX = 0;
    localparam int BUS_IDX  = 1;

    gear_ctrl_t ctrl_q;
    gear_code_e codes [NSTREAM];
    logic       ces   [NSTREAM];
    log2_t      acts  [NSTREAM];

    clkgear_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (gear_wr),
        .wr_data    (gear_ctrl_t'(gear_wdata)),
        .lp_exit    (lp_exit),
        .lp_wake_rst(lp_wake_rst),
        .ctrl_q     (ctrl_q)
    );

    assign codes[CORE_IDX] = ctrl_q.core;
    assign codes[BUS_IDX]  = ctrl_q.bus;

    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        clkgear_div #(.ENABLE_DIV32(ENABLE_DIV32)) u_div (
            .clk     (clk),
            .rst     (rst),
            .code    (codes[s]),
            .ce      (ces[s]),
            .act_log2(acts[s])
        );
    end

    assign core_ce = ces[CORE_IDX];
    assign bus_ce  = ces[BUS_IDX];
    assign core_full_speed = (gear_log2(ctrl_q.core, ENABLE_DIV32) == '0)
                          && (acts[CORE_IDX] == '0);

    // R9
    full_speed_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        core_full_speed |-> core_ce);

    // R1
    reset_release_chk: assert property (@(posedge clk)
        $past(rst) |-> (core_ce && bus_ce && core_full_speed));

endmodule

// File: tb/clock_gear_tb.sv
module clock_gear_tb;

    localparam time CLK_P = 10ns;
    localparam int  WDOG  = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gear_wr = 1'b0;
    logic [5:0] gear_wdata = '0;
    logic       lp_exit = 1'b0;
    logic       lp_wake_rst = 1'b0;
    logic       core_ce_a, bus_ce_a, full_a;
    logic       core_ce_b, bus_ce_b, full_b;

    always #(CLK_P/2) clk = ~clk;

    clock_gear #(.ENABLE_DIV32(1'b1)) u_dut (
        .clk(clk), .rst(rst), .gear_wr(gear_wr), .gear_wdata(gear_wdata),
        .lp_exit(lp_exit), .lp_wake_rst(lp_wake_rst),
        .core_ce(core_ce_a), .bus_ce(bus_ce_a), .core_full_speed(full_a)
    );

    clock_gear #(.ENABLE_DIV32(1'b0)) u_dut16 (
        .clk(clk), .rst(rst), .gear_wr(gear_wr), .gear_wdata(gear_wdata),
        .lp_exit(lp_exit), .lp_wake_rst(lp_wake_rst),
        .core_ce(core_ce_b), .bus_ce(bus_ce_b), .core_full_speed(full_b)
    );

    typedef struct {
        logic [3:0] ce;    // {bus16, core16, bus32, core32}
        logic [1:0] full;  // {16-variant, 32-variant}
        string      req;
    } exp_t;

    exp_t  sb_q[$];
    string cur_req = "R1";
    int    n_chk = 0;
    int    n_fail = 0;

    // Reference model, written from the requirements.
    int m_code [2];          // [stream] 0 core, 1 bus
    int m_act  [2][2];       // [variant][stream]
    int m_cnt  [2][2];

    function automatic int ratio_log(int code, bit en32);
        if (code >= 0 && code <= 4) return code;
        if (code == 5) return en32 ? 5 : 4;
        return 0;
    endfunction

    function automatic bit m_pulse(int v, int s);
        return m_cnt[v][s] == ((1 << m_act[v][s]) - 1);
    endfunction

    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            for (int s = 0; s < 2; s++) begin
                m_code[s] = 0;
                for (int v = 0; v < 2; v++) begin
                    m_act[v][s] = 0;
                    m_cnt[v][s] = 0;
                end
            end
        end else begin
            for (int v = 0; v < 2; v++) begin
                for (int s = 0; s < 2; s++) begin
                    if (m_pulse(v, s)) begin
                        m_cnt[v][s] = 0;
                        m_act[v][s] = ratio_log(m_code[s], v == 0);
                    end else begin
                        m_cnt[v][s] = m_cnt[v][s] + 1;
                    end
                end
            end
            if (lp_exit && lp_wake_rst) begin
                m_code[0] = 0;
                m_code[1] = 0;
            end else if (gear_wr) begin
                m_code[0] = int'(gear_wdata[2:0]);
                m_code[1] = int'(gear_wdata[5:3]);
            end
        end
        e.ce   = {m_pulse(1, 1), m_pulse(1, 0), m_pulse(0, 1), m_pulse(0, 0)};
        e.full[0] = (ratio_log(m_code[0], 1'b1) == 0) && (m_act[0][0] == 0);
        e.full[1] = (ratio_log(m_code[0], 1'b0) == 0) && (m_act[1][0] == 0);
        e.req  = cur_req;
        sb_q.push_back(e);
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check_bit(e.req, "core_ce/div32", core_ce_a, e.ce[0]);
            check_bit(e.req, "bus_ce/div32",  bus_ce_a,  e.ce[1]);
            check_bit(e.req, "core_ce/div16", core_ce_b, e.ce[2]);
            check_bit(e.req, "bus_ce/div16",  bus_ce_b,  e.ce[3]);
            check_bit(e.req, "full/div32",    full_a,    e.full[0]);
            check_bit(e.req, "full/div16",    full_b,    e.full[1]);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_gear(string req, int core, int bus);
        @(negedge clk);
        cur_req    = req;
        gear_wr    = 1'b1;
        gear_wdata = {3'(bus), 3'(core)};
        @(negedge clk);
        gear_wr    = 1'b0;
    endtask

    task automatic wake(string req, bit by_reset);
        @(negedge clk);
        cur_req     = req;
        lp_exit     = 1'b1;
        lp_wake_rst = by_reset;
        @(negedge clk);
        lp_exit     = 1'b0;
        lp_wake_rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * WDOG);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        idle(3);
        rst = 1'b0;
        idle(10);
        // R2 R5: different ratios on the two fields
        write_gear("R2", 2, 3);
        idle(40);
        write_gear("R5", 4, 1);
        idle(70);
        // R3: code 5 reads as /32 or /16 depending on the variant
        write_gear("R3", 5, 0);
        idle(80);
        write_gear("R3", 0, 5);
        idle(70);
        // R4: reserved codes
        write_gear("R4", 6, 7);
        idle(20);
        // R6: rewrite in the middle of a long period
        write_gear("R6", 4, 3);
        idle(5);
        write_gear("R6", 1, 2);
        idle(50);
        // R8: non-reset wake keeps the setting
        wake("R8", 1'b0);
        idle(40);
        // R7: reset wake restores full speed
        write_gear("R7", 5, 4);
        idle(45);
        wake("R7", 1'b1);
        idle(50);
        // R9: bus code does not affect the status
        write_gear("R9", 0, 2);
        idle(20);
        write_gear("R9", 1, 0);
        idle(20);
        // R10: write and reset wake in the same cycle
        @(negedge clk);
        cur_req     = "R10";
        gear_wr     = 1'b1;
        gear_wdata  = {3'd3, 3'd2};
        lp_exit     = 1'b1;
        lp_wake_rst = 1'b1;
        @(negedge clk);
        gear_wr     = 1'b0;
        lp_exit     = 1'b0;
        lp_wake_rst = 1'b0;
        idle(40);
        // R1: reset again mid-run
        cur_req = "R1";
        write_gear("R1", 4, 4);
        idle(7);
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(10);
        finish_run();
    end

endmodule